// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block is the context-switch controller for a processor whose sixteen general registers are kept in ordinary memory. Only three values live on chip: the workspace pointer (the base address of the register block), the program counter and the status word. Because the registers are memory words, switching context is a short run of word reads and writes on a synchronous memory port, steered by a two-word vector. No stack is used.

The sequencer performs three operations. Interrupt entry fetches a new workspace pointer and program counter from the vector of the requesting level, then stores the old pointer, counter and status in registers 13, 14 and 15 of the new workspace. Return reloads all three from those same slots of the current workspace. Branch-and-link stores the program counter in register 11 of the current workspace and jumps to a target. The block also turns a register index into its byte address, so that decode logic elsewhere can reach any register. Requests are taken only while the sequencer is idle, and `busy` covers every cycle of a sequence.

Top module: `ctx_switch_seq`

## Requirements
- R1: After reset `wp`, `pc` and `st` are zero, `busy` is low and `mem_req` is low.
- R2: `reg_addr` equals `wp + 2*reg_sel`, modulo 2^16, at all times.
- R3: An interrupt accepted at level L reads byte address 4L and then 4L+2. The first word becomes `wp` and the second becomes `pc`. `st` is not changed.
- R4: Interrupt entry writes the previous `wp`, `pc` and `st` to the new workspace at byte offsets 26, 28 and 30 (registers 13, 14 and 15).
- R5: Return reads offsets 26, 28 and 30 of the current workspace and loads `wp`, `pc` and `st` from them.
- R6: Branch-and-link writes the current `pc` to offset 22 (register 11) of the current workspace, loads `pc` from `bl_target` and leaves `wp` unchanged.
- R7: `busy` rises in the cycle after a request is accepted. It stays high for 5 cycles on interrupt entry, 4 on return and 1 on branch-and-link. The memory port is quiet whenever `busy` is low.
- R8: Requests that arrive while `busy` is high are ignored and do not change the sequence in progress.
- R9: If several requests arrive in the same idle cycle, interrupt wins over return and return wins over branch-and-link. The losing requests are dropped.
- R10: Memory read data is taken one cycle after the read request. Every address driven on the port is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request |
| irq_level | input | 4 | Level of the requesting interrupt |
| ret_req | input | 1 | Return-from-context request |
| bl_req | input | 1 | Branch-and-link request |
| bl_target | input | 16 | Jump address for branch-and-link |
| reg_sel | input | 4 | Register index to translate |
| reg_addr | output | 16 | Byte address of the selected register |
| wp | output | 16 | Workspace pointer |
| pc | output | 16 | Program counter |
| st | output | 16 | Status word |
| busy | output | 1 | A sequence is running |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 16 | Byte address for the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after the read |

## Verification
An interrupt can arrive in the same idle cycle as a branch-and-link request, and a return can coincide with a branch-and-link. The bench raises each such pair in one cycle. It then checks that only the winner's effect appears: the vector values, or the restored context, rather than `bl_target` in `pc`. It also checks that the `busy` length matches the winning sequence. Requests pulsed in the middle of an interrupt entry are judged the same way: the final `pc` must still be the vector value once the sequencer is idle again.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

   typedef enum logic [3:0] {
      CS_IDLE,
      CS_VEC_WP,
      CS_VEC_PC,
      CS_SAVE_WP,
      CS_SAVE_PC,
      CS_SAVE_ST,
      CS_LD_WP,
      CS_LD_PC,
      CS_LD_ST,
      CS_RET_FIN,
      CS_LINK
   } cs_state_t;

   // register slots whose position the sequences depend on
   localparam int unsigned SLOT_LINK = 11;
   localparam int unsigned SLOT_OWP  = 13;
   localparam int unsigned SLOT_OPC  = 14;
   localparam int unsigned SLOT_OST  = 15;

endpackage

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
   import ctx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      irq_req,
   input  logic      ret_req,
   input  logic      bl_req,
   output cs_state_t state,
   output logic      take_irq,
   output logic      take_ret,
   output logic      take_bl
);

   cs_state_t nxt;

   // fixed priority, only while idle
   always_comb begin
      take_irq = (state == CS_IDLE) && irq_req;
      take_ret = (state == CS_IDLE) && !irq_req && ret_req;
      take_bl  = (state == CS_IDLE) && !irq_req && !ret_req && bl_req;
   end

   always_comb begin
      nxt = state;
      unique case (state)
         CS_IDLE: begin
            if (take_irq)      nxt = CS_VEC_WP;
            else if (take_ret) nxt = CS_LD_WP;
            else if (take_bl)  nxt = CS_LINK;
         end
         CS_VEC_WP:  nxt = CS_VEC_PC;
         CS_VEC_PC:  nxt = CS_SAVE_WP;
         CS_SAVE_WP: nxt = CS_SAVE_PC;
         CS_SAVE_PC: nxt = CS_SAVE_ST;
         CS_SAVE_ST: nxt = CS_IDLE;
         CS_LD_WP:   nxt = CS_LD_PC;
         CS_LD_PC:   nxt = CS_LD_ST;
         CS_LD_ST:   nxt = CS_RET_FIN;
         CS_RET_FIN: nxt = CS_IDLE;
         CS_LINK:    nxt = CS_IDLE;
         default:    nxt = CS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= CS_IDLE;
      else        state <= nxt;
   end

   AST_IRQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CS_IDLE && irq_req) |=> state == CS_VEC_WP); // R9
   AST_RET_OVER_BL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CS_IDLE && !irq_req && ret_req && bl_req) |=> state == CS_LD_WP); // R9
   AST_NO_DIVERT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CS_VEC_PC) |=> state == CS_SAVE_WP); // R8

endmodule

// File: rtl/ctx_addr_unit.sv
module ctx_addr_unit
   import ctx_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned RSW      = 4,
   parameter int unsigned LVLW     = 4,
   parameter logic [15:0] VEC_BASE = 16'h0000
) (
   input  logic [AW-1:0]   wp,
   input  logic [RSW-1:0]  reg_sel,
   input  logic [LVLW-1:0] lvl,
   input  cs_state_t       state,
   output logic [AW-1:0]   reg_addr,
   output logic [AW-1:0]   mem_addr
);

   localparam int unsigned VAW = LVLW + 2;

   logic [AW-1:0] vec_addr;
   logic [RSW-1:0] slot;
   logic [AW-1:0] slot_addr;

   generate
      if (AW > VAW) begin : g_vec_wide
         assign vec_addr = VEC_BASE[AW-1:0] + {{(AW-VAW){1'b0}}, lvl, 2'b00};
      end else begin : g_vec_exact
         assign vec_addr = VEC_BASE[AW-1:0] + AW'({lvl, 2'b00});
      end
   endgenerate

   assign reg_addr  = wp + {{(AW-RSW-1){1'b0}}, reg_sel, 1'b0};

   always_comb begin
      unique case (state)
         CS_SAVE_WP, CS_LD_WP: slot = RSW'(SLOT_OWP);
         CS_SAVE_PC, CS_LD_PC: slot = RSW'(SLOT_OPC);
         CS_SAVE_ST, CS_LD_ST: slot = RSW'(SLOT_OST);
         default:              slot = RSW'(SLOT_LINK);
      endcase
   end

   assign slot_addr = wp + {{(AW-RSW-1){1'b0}}, slot, 1'b0};

   always_comb begin
      unique case (state)
         CS_VEC_WP: mem_addr = vec_addr;
         CS_VEC_PC: mem_addr = vec_addr + AW'(2);
         default:   mem_addr = slot_addr;
      endcase
   end

endmodule

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq
   import ctx_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned DW       = 16,
   parameter int unsigned NREG     = 16,
   parameter int unsigned LVLW     = 4,
   parameter logic [15:0] VEC_BASE = 16'h0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_req,
   input  logic [LVLW-1:0] irq_level,
   input  logic            ret_req,
   input  logic            bl_req,
   input  logic [AW-1:0]   bl_target,
   input  logic [$clog2(NREG)-1:0] reg_sel,
   output logic [AW-1:0]   reg_addr,
   output logic [AW-1:0]   wp,
   output logic [AW-1:0]   pc,
   output logic [DW-1:0]   st,
   output logic            busy,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata
);

   localparam int unsigned RSW = $clog2(NREG);

   initial begin
      AST_WIDTH_MATCH: assert (AW == DW)
         else $error("pointer and data widths must match"); // R3
      AST_ENOUGH_REGS: assert (NREG >= 16 && (1 << RSW) == NREG)
         else $error("register count must be a power of two of at least 16"); // R4
   end

   cs_state_t state;
   logic take_irq, take_ret, take_bl;
   logic [LVLW-1:0] lvl_q;
   logic [AW-1:0] sv_wp, sv_pc, tmp;
   logic [DW-1:0] sv_st;

   ctx_seq_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_req  (irq_req),
      .ret_req  (ret_req),
      .bl_req   (bl_req),
      .state    (state),
      .take_irq (take_irq),
      .take_ret (take_ret),
      .take_bl  (take_bl)
   );

   ctx_addr_unit #(
      .AW       (AW),
      .RSW      (RSW),
      .LVLW     (LVLW),
      .VEC_BASE (VEC_BASE)
   ) u_addr (
      .wp       (wp),
      .reg_sel  (reg_sel),
      .lvl      (lvl_q),
      .state    (state),
      .reg_addr (reg_addr),
      .mem_addr (mem_addr)
   );

   assign busy = (state != CS_IDLE);

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_wdata = '0;
      unique case (state)
         CS_VEC_WP, CS_VEC_PC, CS_LD_WP, CS_LD_PC, CS_LD_ST: mem_req = 1'b1;
         CS_SAVE_WP: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = sv_wp; end
         CS_SAVE_PC: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = sv_pc; end
         CS_SAVE_ST: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = sv_st; end
         CS_LINK:    begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = pc; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         pc    <= '0;
         st    <= '0;
         sv_wp <= '0;
         sv_pc <= '0;
         sv_st <= '0;
         tmp   <= '0;
         lvl_q <= '0;
      end else begin
         if (take_irq) begin
            sv_wp <= wp;
            sv_pc <= pc;
            sv_st <= st;
            lvl_q <= irq_level;
         end
         if (take_bl) tmp <= bl_target;
         unique case (state)
            CS_VEC_PC:  wp  <= mem_rdata;
            CS_SAVE_WP: pc  <= mem_rdata;
            CS_LD_PC:   tmp <= mem_rdata;
            CS_LD_ST:   pc  <= mem_rdata;
            CS_RET_FIN: begin st <= mem_rdata; wp <= tmp; end
            CS_LINK:    pc  <= tmp;
            default: ;
         endcase
      end
   end

   AST_MEM_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[0] == 1'b0)); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req); // R7
   AST_BUSY_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && irq_req) |=> busy); // R7
   AST_LINK_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && bl_req && !irq_req && !ret_req) |=> (mem_we && mem_wdata == $past(pc))); // R6
   AST_LINK_WP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_we && state == CS_LINK) |=> (wp == $past(wp) && !busy)); // R6

endmodule

// File: tb/ctx_switch_seq_test.sv
`timescale 1ns/1ps
module ctx_switch_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic [3:0]  irq_level = '0;
   logic        ret_req = 1'b0;
   logic        bl_req = 1'b0;
   logic [15:0] bl_target = '0;
   logic [3:0]  reg_sel = '0;
   logic [15:0] reg_addr, wp, pc, st, mem_addr, mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        busy, mem_req, mem_we;

   logic [15:0] mem [0:255];
   int errors = 0;
   int checks = 0;
   int odd_cnt = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ctx_switch_seq uut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_level(irq_level),
      .ret_req(ret_req), .bl_req(bl_req), .bl_target(bl_target),
      .reg_sel(reg_sel), .reg_addr(reg_addr), .wp(wp), .pc(pc), .st(st),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // word memory, read data one cycle after the request
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[8:1]];
      end
   end

   always @(negedge clk) if (rst_n && mem_req && mem_addr[0]) odd_cnt++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // op: 1 irq(a=level) 2 return 3 link(a=target) 4 poke mem[a]=b
   task automatic run_op(input int op, input logic [15:0] a, output int n);
      n = 0;
      @(negedge clk);
      irq_req   = (op == 1);
      irq_level = a[3:0];
      ret_req   = (op == 2);
      bl_req    = (op == 3);
      bl_target = a;
      @(negedge clk);
      irq_req = 1'b0; ret_req = 1'b0; bl_req = 1'b0;
      while (busy && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   localparam logic [95:0] TBL [0:8] = '{
      {16'd1, 16'h0002, 16'h0000, 16'h0140, 16'h1020, 16'h0000},
      {16'd3, 16'h0400, 16'h0000, 16'h0140, 16'h0400, 16'h0000},
      {16'd1, 16'h0005, 16'h0000, 16'h01A0, 16'h1050, 16'h0000},
      {16'd3, 16'h0800, 16'h0000, 16'h01A0, 16'h0800, 16'h0000},
      {16'd4, 16'h01BE, 16'hA5A5, 16'h01A0, 16'h0800, 16'h0000},
      {16'd2, 16'h0000, 16'h0000, 16'h0140, 16'h0400, 16'hA5A5},
      {16'd1, 16'h0007, 16'h0000, 16'h01E0, 16'h1070, 16'hA5A5},
      {16'd2, 16'h0000, 16'h0000, 16'h0140, 16'h0400, 16'hA5A5},
      {16'd2, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}
   };

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int l = 0; l < 16; l++) begin
         mem[2*l]   = 16'h0100 + 16'(32*l);
         mem[2*l+1] = 16'h1000 + 16'(16*l);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 wp", wp, 0);
      chk("R1 pc", pc, 0);
      chk("R1 st", st, 0);
      chk("R1 busy", busy, 0);
      chk("R1 mem_req", mem_req, 0);
      reg_sel = 4'd15;
      #1 chk("R2 reset reg15", reg_addr, 16'h001E);

      for (int i = 0; i < 9; i++) begin
         int op;
         op = int'(TBL[i][95:80]);
         if (op == 4) mem[TBL[i][72:65]] = TBL[i][63:48];
         else begin
            run_op(op, TBL[i][79:64], n);
            // R7 busy length per sequence
            chk(op == 1 ? "R7 irq busy" : op == 2 ? "R7 ret busy" : "R7 link busy",
                n, op == 1 ? 5 : op == 2 ? 4 : 1);
         end
         // R3 R5 R6 resulting context
         chk(op == 1 ? "R3 wp" : op == 2 ? "R5 wp" : "R6 wp", wp, TBL[i][47:32]);
         chk(op == 1 ? "R3 pc" : op == 2 ? "R5 pc" : "R6 pc", pc, TBL[i][31:16]);
         chk(op == 1 ? "R3 st" : op == 2 ? "R5 st" : "R6 st", st, TBL[i][15:0]);
         if (i == 6) begin
            reg_sel = 4'd15;
            #1 chk("R2 reg15 at 01E0", reg_addr, 16'h01FE);
         end
      end

      // R4 saved contexts, R6 link words
      chk("R4 R13 slot", mem[8'hFD], 16'h0140);
      chk("R4 R14 slot", mem[8'hFE], 16'h0400);
      chk("R4 R15 slot", mem[8'hFF], 16'hA5A5);
      chk("R4 nested R13", mem[8'hDD], 16'h0140);
      chk("R4 nested R14", mem[8'hDE], 16'h0400);
      chk("R6 link ws0140", mem[8'hAB], 16'h1020);
      chk("R6 link ws01A0", mem[8'hDB], 16'h1050);

      // R9 interrupt and link in the same idle cycle
      @(negedge clk);
      irq_req = 1'b1; irq_level = 4'd1; bl_req = 1'b1; bl_target = 16'h0900;
      @(negedge clk);
      irq_req = 1'b0; bl_req = 1'b0;
      n = 0;
      while (busy && n < 100) begin n++; @(negedge clk); end
      chk("R9 irq beats link busy", n, 5);
      chk("R9 irq beats link wp", wp, 16'h0120);
      chk("R9 irq beats link pc", pc, 16'h1010);

      // R9 return and link in the same idle cycle
      @(negedge clk);
      ret_req = 1'b1; bl_req = 1'b1; bl_target = 16'h0900;
      @(negedge clk);
      ret_req = 1'b0; bl_req = 1'b0;
      n = 0;
      while (busy && n < 100) begin n++; @(negedge clk); end
      chk("R9 ret beats link busy", n, 4);
      chk("R9 ret beats link pc", pc, 16'h0000);
      chk("R9 ret beats link wp", wp, 16'h0000);

      // R8 requests during an interrupt entry are dropped
      @(negedge clk);
      irq_req = 1'b1; irq_level = 4'd2;
      @(negedge clk);
      irq_req = 1'b0;
      @(negedge clk);
      bl_req = 1'b1; ret_req = 1'b1; bl_target = 16'h0ABC;
      @(negedge clk);
      bl_req = 1'b0; ret_req = 1'b0;
      n = 0;
      while (busy && n < 100) begin n++; @(negedge clk); end
      repeat (3) @(negedge clk);
      chk("R8 busy idle", busy, 0);
      chk("R8 pc kept", pc, 16'h1020);
      chk("R8 wp kept", wp, 16'h0140);
      reg_sel = 4'd3;
      #1 chk("R2 reg3 at 0140", reg_addr, 16'h0146);
      chk("R10 even addresses", odd_cnt, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule